// File: doc/BRIEF.md
# USB bit-rate sample timer

This block divides the core clock down to a USB bit period and marks the point in each bit where the receive logic should sample the line. An 8-bit reload value sets the period in core clocks. A down counter runs through that many clocks and then starts the next period. It raises a one-cycle sample strobe at the middle of the period and a one-cycle boundary pulse in the last cycle of the period. The middle falls at floor(N/2) elapsed clocks, so odd divisors work as well as even ones.

The incoming differential line state passes through a two-flop synchroniser. In edge-snap mode, every change of that state ends the current period early and restarts the phase. Sampling then stays centred on the sender's bits even when the two clocks drift apart. Reload values below 4 are raised to 4. A new reload value is taken only while the block is disabled or in a boundary cycle. A disabled timer holds its counter at the reload value and gives no pulses.

Top module: `usb_bit_timer`

## Requirements
- R1: While rst_ni is low, sample_o and bit_edge_o are both low.
- R2: With enable_i high, a fixed period N and no snap, bit_edge_o is high exactly in the last cycle of each N-cycle period (elapsed count N-1, where the first enabled cycle is elapsed 0), and low in all other cycles.
- R3: sample_o is high exactly at elapsed count floor(N/2) of each period, for odd and even N, and low in all other cycles.
- R4: A reload value of 0, 1, 2 or 3 gives the same timing as a reload value of 4.
- R5: reload_i is taken only in a cycle where enable_i is low or bit_edge_o is high. That value sets the length of the following period. Changes at any other time have no effect on the outputs.
- R6: While enable_i is low, no pulses appear on sample_o or bit_edge_o. The first cycle with enable_i high is elapsed 0 of a period whose length comes from reload_i in the last disabled cycle.
- R7: With snap_en_i high, any change of the 2-bit line_i value (all four codes 00, 01, 10, 11 count as distinct states) presented during cycle c makes bit_edge_o high in cycle c+2. Cycle c+3 is then elapsed 0 of a new period.
- R8: With snap_en_i low, changes of line_i have no effect on sample_o or bit_edge_o.
- R9: The full 8-bit reload range is usable: reload values 133 and 255 give periods of 133 and 255 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Runs the divider when high |
| snap_en_i | input | 1 | Edge-snap mode: line transitions restart the phase |
| reload_i | input | 8 | Bit period in core clocks (values below 4 are treated as 4) |
| line_i | input | 2 | Differential line state, asynchronous to clk_i |
| sample_o | output | 1 | One-cycle strobe at mid-bit |
| bit_edge_o | output | 1 | One-cycle pulse in the last cycle of each bit period |

## Verification
Every reload value from 0 to 40 runs for three periods. This separates odd from even sample placement, shows the values below 4 taking the clamped timing, and exposes any off-by-one in the terminal count. The values 133 and 255 show that the upper bits of the counter work. In other runs the reload value changes in mid-period and enable drops in mid-period, to tell a boundary-only load apart from an immediate one. Line transitions go through all four line codes at different phases, once with snap on and once with snap off, to show both the two-cycle synchroniser delay and that transitions are ignored when snap is off.

// File: rtl/usb_bit_timer_pkg.sv
package usb_bit_timer_pkg;
  localparam int LINE_W = 2;
  typedef logic [LINE_W-1:0] line_t;
endpackage

// File: rtl/ubt_line_sync.sv
module ubt_line_sync
  import usb_bit_timer_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  line_t line_i,
  output logic  edge_o
);
  line_t stg_q [STAGES+1];

  for (genvar i = 0; i <= STAGES; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[i] <= '0;
      else if (i == 0) stg_q[i] <= line_i;
      else             stg_q[i] <= stg_q[i-1];
    end
  end

  // last stage keeps the previous synchronised value for edge compare
  assign edge_o = stg_q[STAGES-1] != stg_q[STAGES];
endmodule

// File: rtl/ubt_period_reg.sv
module ubt_period_reg #(
  parameter int W       = 8,
  parameter int MIN_DIV = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         enable_i,
  input  logic         boundary_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] load_val_o,
  output logic [W-1:0] per_o
);
  localparam logic [W-1:0] MinVal = W'(MIN_DIV);

  logic [W-1:0] per_q;

  assign load_val_o = (reload_i < MinVal) ? MinVal : reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     per_q <= MinVal;
    else if (!enable_i || boundary_i) per_q <= load_val_o;
  end

  assign per_o = per_q;
endmodule

// File: rtl/ubt_phase_cnt.sv
module ubt_phase_cnt #(
  parameter int W       = 8,
  parameter int MIN_DIV = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         enable_i,
  input  logic         restart_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] per_i,
  output logic [W-1:0] cnt_o,
  output logic         term_o,
  output logic         mid_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] mid_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= W'(MIN_DIV);
    else if (!enable_i || restart_i) cnt_q <= load_val_i;
    else                             cnt_q <= cnt_q - 1'b1;
  end

  // counter runs per..1; mid at floor(per/2) elapsed = ceil(per/2) remaining
  assign mid_cnt = per_i - (per_i >> 1);
  assign term_o  = cnt_q == W'(1);
  assign mid_o   = enable_i && (cnt_q == mid_cnt);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/usb_bit_timer.sv
module usb_bit_timer
  import usb_bit_timer_pkg::*;
#(
  parameter int W           = 8,
  parameter int MIN_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         enable_i,
  input  logic         snap_en_i,
  input  logic [W-1:0] reload_i,
  input  logic [1:0]   line_i,
  output logic         sample_o,
  output logic         bit_edge_o
);
  logic         line_edge;
  logic         term;
  logic         mid;
  logic         boundary;
  logic [W-1:0] load_val;
  logic [W-1:0] per;
  logic [W-1:0] cnt;

  ubt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_t'(line_i)),
    .edge_o (line_edge)
  );

  ubt_period_reg #(.W(W), .MIN_DIV(MIN_DIV)) u_per (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .boundary_i (boundary),
    .reload_i   (reload_i),
    .load_val_o (load_val),
    .per_o      (per)
  );

  ubt_phase_cnt #(.W(W), .MIN_DIV(MIN_DIV)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .restart_i  (boundary),
    .load_val_i (load_val),
    .per_i      (per),
    .cnt_o      (cnt),
    .term_o     (term),
    .mid_o      (mid)
  );

  // a snapped edge counts as a period boundary
  assign boundary   = enable_i && (term || (snap_en_i && line_edge));
  assign bit_edge_o = boundary;
  assign sample_o   = mid;
endmodule

// File: rtl/usb_bit_timer_chk.sv
module usb_bit_timer_chk #(
  parameter int W       = 8,
  parameter int MIN_DIV = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         enable_i,
  input logic         snap_en_i,
  input logic         sample_i,
  input logic         boundary_i,
  input logic [W-1:0] cnt_i,
  input logic [W-1:0] per_i
);
  p_no_overlap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snap_en_i && sample_i) |-> !boundary_i);

  p_sample_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |=> !sample_i);

  p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) && (cnt_i <= per_i) && (per_i >= W'(MIN_DIV)));

  p_per_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !boundary_i) |=> $stable(per_i));

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> (!sample_i && !boundary_i));

  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i |=> (cnt_i == per_i));
endmodule

bind usb_bit_timer usb_bit_timer_chk #(.W(W), .MIN_DIV(MIN_DIV)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .snap_en_i  (snap_en_i),
  .sample_i   (sample_o),
  .boundary_i (bit_edge_o),
  .cnt_i      (cnt),
  .per_i      (per)
);

// File: tb/usb_bit_timer_test.sv
module usb_bit_timer_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_i = 1'b0;
  logic       snap_en_i = 1'b0;
  logic [7:0] reload_i = 8'd4;
  logic [1:0] line_i = 2'b00;
  logic       sample_o;
  logic       bit_edge_o;

  // values applied at the next cycle
  logic       n_en = 1'b0;
  logic       n_snap = 1'b0;
  logic [7:0] n_rld = 8'd4;
  logic [1:0] n_line = 2'b00;

  // reference model
  int         e_cnt = 0;
  int         per_n = 4;
  logic [1:0] h1 = 2'b00, h2 = 2'b00, h3 = 2'b00;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  usb_bit_timer uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .snap_en_i  (snap_en_i),
    .reload_i   (reload_i),
    .line_i     (line_i),
    .sample_o   (sample_o),
    .bit_edge_o (bit_edge_o)
  );

  always #4 clk_i = ~clk_i;

  function automatic int clampv(input logic [7:0] v);
    return (v < 8'd4) ? 4 : int'(v);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // one clock: drive after posedge, check at negedge, advance model
  task automatic cyc(input string tag_s, input string tag_b);
    bit vis, exp_s, exp_b;
    @(posedge clk_i);
    #1;
    h3 = h2; h2 = h1; h1 = line_i;
    enable_i  = n_en;
    snap_en_i = n_snap;
    reload_i  = n_rld;
    line_i    = n_line;
    @(negedge clk_i);
    if (!enable_i) begin
      exp_s = 1'b0;
      exp_b = 1'b0;
    end else begin
      // line value of cycle c-2 versus c-3
      vis   = snap_en_i && (h2 != h3);
      exp_s = (e_cnt == per_n / 2);
      exp_b = (e_cnt == per_n - 1) || vis;
    end
    chk(tag_s, "sample_o", int'(sample_o), int'(exp_s));
    chk(tag_b, "bit_edge_o", int'(bit_edge_o), int'(exp_b));
    if (!enable_i || exp_b) begin
      e_cnt = 0;
      per_n = clampv(reload_i);
    end else begin
      e_cnt++;
    end
  endtask

  task automatic run(input int n, input string ts, input string tb);
    for (int i = 0; i < n; i++) cyc(ts, tb);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk("R1", "sample_o", int'(sample_o), 0);
      chk("R1", "bit_edge_o", int'(bit_edge_o), 0);
    end
    @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R6: disabled, reload moving, no pulses
    for (int i = 0; i < 6; i++) begin
      n_rld = 8'(i * 7);
      cyc("R6", "R6");
    end

    // R2/R3/R4: sweep all small divisors, three periods each
    for (int n = 0; n <= 40; n++) begin
      n_en = 1'b0;
      n_rld = 8'(n);
      run(2, "R6", "R6");
      n_en = 1'b1;
      if (n < 4) run(3 * 4 + 1, "R4", "R4");
      else       run(3 * n + 1, "R3", "R2");
    end

    // R9: upper part of range
    n_en = 1'b0; n_rld = 8'd133; run(2, "R6", "R6");
    n_en = 1'b1; run(2 * 133 + 3, "R9", "R9");
    n_en = 1'b0; n_rld = 8'd255; run(2, "R6", "R6");
    n_en = 1'b1; run(2 * 255 + 3, "R9", "R9");

    // R5: reload changes mid-period only apply at the boundary
    n_en = 1'b0; n_rld = 8'd10; run(2, "R6", "R6");
    n_en = 1'b1; run(3, "R5", "R5");
    n_rld = 8'd20; run(2, "R5", "R5");
    n_rld = 8'd7;  run(2, "R5", "R5");
    n_rld = 8'd2;  run(20, "R5", "R5");
    n_rld = 8'd13; run(40, "R5", "R5");

    // R6: enable dropped mid-period restarts the phase
    n_rld = 8'd9; run(14, "R6", "R6");
    n_en = 1'b0; run(2, "R6", "R6");
    n_en = 1'b1; run(20, "R6", "R6");

    // R7: snap on, transitions through all line codes at several phases
    n_snap = 1'b1;
    n_rld = 8'd12;
    n_en = 1'b0; run(2, "R6", "R6");
    n_en = 1'b1; run(5, "R7", "R7");
    n_line = 2'b10; run(8, "R7", "R7");
    n_line = 2'b01; run(3, "R7", "R7");
    n_line = 2'b00; run(17, "R7", "R7");
    n_line = 2'b11; run(1, "R7", "R7");
    n_line = 2'b10; run(11, "R7", "R7");
    n_line = 2'b01; run(30, "R7", "R7");

    // R8: snap off, transitions ignored
    n_snap = 1'b0;
    n_en = 1'b0; run(2, "R6", "R6");
    n_en = 1'b1; run(4, "R8", "R8");
    n_line = 2'b10; run(6, "R8", "R8");
    n_line = 2'b00; run(2, "R8", "R8");
    n_line = 2'b11; run(9, "R8", "R8");
    n_line = 2'b01; run(30, "R8", "R8");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule